// File: doc/BRIEF.md
# Co-unit Memory Port Arbiter

This block sits on the core side of an attached co-unit. It lets two requesters share one downstream memory port. The first requester is the core's own load/store path. The second is the co-unit's memory command channel. The block picks one request and forwards it as a single registered command. It records which requester issued that command and steers the downstream response back to that requester.

The co-unit raises a holdup input before it starts its own memory accesses. It keeps the input high until it has finished them. While holdup is high, no new core load or store is accepted. A core access that was already accepted still runs to completion. Because of this, a co-unit instruction can start memory traffic at any point before it retires, and it cannot deadlock against core loads and stores that are waiting behind it.

The block handles one command at a time. A command is accepted on a valid/ready handshake. It is then held on the downstream port until that port accepts it. The block waits for the downstream response and holds it towards its owner until the owner takes it. A command that carries the reserved size code is never forwarded. The block answers it directly with an error response.

Top module: `cmp_mem_arbiter`

## Requirements
- R1: After a synchronous reset, `mem_cmd_valid`, `mem_rsp_ready`, `core_rsp_valid` and `cu_rsp_valid` are low, and neither command ready is high while its valid is low.
- R2: With `cu_holdup` low and the block idle, a valid core command is accepted in the same cycle (`core_cmd_ready` high). In the next cycle it appears on the downstream port with the same address, read flag, write data and size.
- R3: While `cu_holdup` is high, `core_cmd_ready` stays low and no core command reaches the downstream port. A co-unit command presented while the block is idle is accepted and forwarded.
- R4: A core command accepted before `cu_holdup` rises is still forwarded, and its response is still delivered to the core.
- R5: A downstream response is delivered only to the requester that issued the command, with the read data and error bit unchanged. The other requester's response valid stays low.
- R6: A command whose size is 2'b11 (reserved) is accepted but not forwarded. In the cycle after acceptance its requester sees a response with error bit 1 and read data 0.
- R7: Once `mem_cmd_valid` is high, it stays high with the same address, read flag, data and size until `mem_cmd_ready` is sampled high.
- R8: Only one command is outstanding at a time. Both command readies stay low from acceptance until the response has been taken. A response valid stays high, with stable data, until the owner's ready is high.
- R9: With `cu_holdup` low, a core command wins over a co-unit command presented in the same cycle.
- R10: The read flag (1 = read, 0 = write) and the size codes 2'b00 byte, 2'b01 half-word and 2'b10 word pass to the downstream port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_cmd_valid | input | 1 | Core load/store command valid |
| core_cmd_ready | output | 1 | Core command accepted |
| core_cmd_addr | input | ADDR_W | Core command address |
| core_cmd_read | input | 1 | Core command: 1 read, 0 write |
| core_cmd_wdata | input | DATA_W | Core write data |
| core_cmd_size | input | 2 | Core access size code |
| core_rsp_valid | output | 1 | Response valid towards the core |
| core_rsp_ready | input | 1 | Core takes the response |
| core_rsp_rdata | output | DATA_W | Read data towards the core |
| core_rsp_err | output | 1 | Error flag towards the core |
| cu_holdup | input | 1 | Co-unit owns the memory path; blocks new core commands |
| cu_cmd_valid | input | 1 | Co-unit memory command valid |
| cu_cmd_ready | output | 1 | Co-unit command accepted |
| cu_cmd_addr | input | ADDR_W | Co-unit command address |
| cu_cmd_read | input | 1 | Co-unit command: 1 read, 0 write |
| cu_cmd_wdata | input | DATA_W | Co-unit write data |
| cu_cmd_size | input | 2 | Co-unit access size code |
| cu_rsp_valid | output | 1 | Response valid towards the co-unit |
| cu_rsp_ready | input | 1 | Co-unit takes the response |
| cu_rsp_rdata | output | DATA_W | Read data towards the co-unit |
| cu_rsp_err | output | 1 | Error flag towards the co-unit |
| mem_cmd_valid | output | 1 | Downstream command valid |
| mem_cmd_ready | input | 1 | Downstream command accepted |
| mem_cmd_addr | output | ADDR_W | Downstream address |
| mem_cmd_read | output | 1 | Downstream read flag |
| mem_cmd_wdata | output | DATA_W | Downstream write data |
| mem_cmd_size | output | 2 | Downstream size code |
| mem_rsp_valid | input | 1 | Downstream response valid |
| mem_rsp_ready | output | 1 | Block accepts the downstream response |
| mem_rsp_rdata | input | DATA_W | Downstream read data |
| mem_rsp_err | input | 1 | Downstream error flag |

## Verification
The arbitration is tried with four input patterns: a core request alone, a co-unit request alone under holdup, both requests together with holdup low, and a core request that is already in flight when holdup rises. These patterns separate three decisions that could otherwise be confused: priority, blocking, and completion of work already accepted. Reads and writes are run at byte, half-word and word sizes. Downstream responses carry distinct data and error values, so a swapped field or a response routed to the wrong requester shows up. Stall cycles on the downstream ready and on the requester's response ready show whether held commands and held responses stay stable. A reserved-size request shows that such a command is answered locally and never reaches the downstream port.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int SIZE_W = 2;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'b00;
  localparam logic [SIZE_W-1:0] SZ_HALF = 2'b01;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'b10;
  localparam logic [SIZE_W-1:0] SZ_RSV  = 2'b11;

  typedef enum logic {
    SRC_CORE = 1'b0,
    SRC_CU   = 1'b1
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REPLY = 2'd3
  } arb_st_e;
endpackage

// File: rtl/cmp_grant.sv
module cmp_grant
  import cmp_pkg::*;
(
  input  logic idle,
  input  logic holdup,
  input  logic core_valid,
  input  logic cu_valid,
  output logic take_core,
  output logic take_cu,
  output src_e win_src
);
  // Holdup shuts out new core requests; otherwise the core has priority.
  always_comb begin
    take_core = idle && !holdup && core_valid;
    take_cu   = idle && cu_valid && (holdup || !core_valid);
    win_src   = take_cu ? SRC_CU : SRC_CORE;
  end
endmodule

// File: rtl/cmp_owner_track.sv
module cmp_owner_track
  import cmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  src_e push_src,
  input  logic pop,
  output logic full,
  output src_e owner
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      owner <= SRC_CORE;
    end else if (push) begin
      full  <= 1'b1;
      owner <= push_src;
    end else if (pop) begin
      full  <= 1'b0;
    end
  end

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R8
  pop_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> full);
endmodule

// File: rtl/cmp_rsp_steer.sv
module cmp_rsp_steer
  import cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  src_e              load_src,
  input  logic [DATA_W-1:0] load_rdata,
  input  logic              load_err,
  input  logic              core_ready,
  input  logic              cu_ready,
  output logic              core_valid,
  output logic              cu_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              done
);
  logic hold_v;
  src_e hold_src;

  assign core_valid = hold_v && (hold_src == SRC_CORE);
  assign cu_valid   = hold_v && (hold_src == SRC_CU);
  assign done       = (core_valid && core_ready) || (cu_valid && cu_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_src <= SRC_CORE;
      rdata    <= '0;
      err      <= 1'b0;
    end else if (load) begin
      hold_v   <= 1'b1;
      hold_src <= load_src;
      rdata    <= load_rdata;
      err      <= load_err;
    end else if (done) begin
      hold_v   <= 1'b0;
    end
  end

  // R5
  one_rsp_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(core_valid && cu_valid));

  // R8
  rsp_held_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !done) |=> (hold_v && $stable(rdata) && $stable(err)));
endmodule

// File: rtl/cmp_mem_arbiter.sv
module cmp_mem_arbiter
  import cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_cmd_valid,
  output logic              core_cmd_ready,
  input  logic [ADDR_W-1:0] core_cmd_addr,
  input  logic              core_cmd_read,
  input  logic [DATA_W-1:0] core_cmd_wdata,
  input  logic [1:0]        core_cmd_size,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              core_rsp_err,
  input  logic              cu_holdup,
  input  logic              cu_cmd_valid,
  output logic              cu_cmd_ready,
  input  logic [ADDR_W-1:0] cu_cmd_addr,
  input  logic              cu_cmd_read,
  input  logic [DATA_W-1:0] cu_cmd_wdata,
  input  logic [1:0]        cu_cmd_size,
  output logic              cu_rsp_valid,
  input  logic              cu_rsp_ready,
  output logic [DATA_W-1:0] cu_rsp_rdata,
  output logic              cu_rsp_err,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_cmd_read,
  output logic [DATA_W-1:0] mem_cmd_wdata,
  output logic [1:0]        mem_cmd_size,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              mem_rsp_err
);
  arb_st_e           st;
  logic              idle;
  logic              take_core;
  logic              take_cu;
  src_e              win_src;
  logic              accept;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_read;
  logic [DATA_W-1:0] sel_wdata;
  logic [SIZE_W-1:0] sel_size;
  logic              bad_size;
  logic              track_full;
  src_e              owner;
  logic              rsp_take;
  logic              rsp_load;
  src_e              rsp_src;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_err;
  logic              rsp_done;
  logic [DATA_W-1:0] shared_rdata;
  logic              shared_err;

  assign idle = (st == ST_IDLE);

  cmp_grant u_grant (
    .idle       (idle),
    .holdup     (cu_holdup),
    .core_valid (core_cmd_valid),
    .cu_valid   (cu_cmd_valid),
    .take_core  (take_core),
    .take_cu    (take_cu),
    .win_src    (win_src)
  );

  assign core_cmd_ready = take_core;
  assign cu_cmd_ready   = take_cu;
  assign accept         = take_core || take_cu;

  always_comb begin
    if (take_cu) begin
      sel_addr  = cu_cmd_addr;
      sel_read  = cu_cmd_read;
      sel_wdata = cu_cmd_wdata;
      sel_size  = cu_cmd_size;
    end else begin
      sel_addr  = core_cmd_addr;
      sel_read  = core_cmd_read;
      sel_wdata = core_cmd_wdata;
      sel_size  = core_cmd_size;
    end
  end

  assign bad_size = (sel_size == SZ_RSV);

  cmp_owner_track u_track (
    .clk      (clk),
    .rst      (rst),
    .push     (accept),
    .push_src (win_src),
    .pop      (rsp_done),
    .full     (track_full),
    .owner    (owner)
  );

  // A downstream response uses the recorded owner; a rejected size
  // answers the requester that is being accepted right now.
  assign mem_rsp_ready = (st == ST_WAIT);
  assign rsp_take      = mem_rsp_ready && mem_rsp_valid;
  assign rsp_load      = rsp_take || (accept && bad_size);
  assign rsp_src       = rsp_take ? owner : win_src;
  assign rsp_rdata     = rsp_take ? mem_rsp_rdata : '0;
  assign rsp_err       = rsp_take ? mem_rsp_err : 1'b1;

  cmp_rsp_steer #(.DATA_W(DATA_W)) u_steer (
    .clk        (clk),
    .rst        (rst),
    .load       (rsp_load),
    .load_src   (rsp_src),
    .load_rdata (rsp_rdata),
    .load_err   (rsp_err),
    .core_ready (core_rsp_ready),
    .cu_ready   (cu_rsp_ready),
    .core_valid (core_rsp_valid),
    .cu_valid   (cu_rsp_valid),
    .rdata      (shared_rdata),
    .err        (shared_err),
    .done       (rsp_done)
  );

  assign core_rsp_rdata = shared_rdata;
  assign core_rsp_err   = shared_err;
  assign cu_rsp_rdata   = shared_rdata;
  assign cu_rsp_err     = shared_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      mem_cmd_valid <= 1'b0;
      mem_cmd_addr  <= '0;
      mem_cmd_read  <= 1'b0;
      mem_cmd_wdata <= '0;
      mem_cmd_size  <= SZ_BYTE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (bad_size) begin
              st <= ST_REPLY;
            end else begin
              st            <= ST_ISSUE;
              mem_cmd_valid <= 1'b1;
              mem_cmd_addr  <= sel_addr;
              mem_cmd_read  <= sel_read;
              mem_cmd_wdata <= sel_wdata;
              mem_cmd_size  <= sel_size;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_cmd_ready) begin
            st            <= ST_WAIT;
            mem_cmd_valid <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) st <= ST_REPLY;
        end
        default: begin
          if (rsp_done) st <= ST_IDLE;
        end
      endcase
    end
  end

  // R3
  holdup_blocks_core_chk: assert property (@(posedge clk) disable iff (rst)
    cu_holdup |-> !core_cmd_ready);

  // R9
  core_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!cu_holdup && core_cmd_valid) |-> !cu_cmd_ready);

  // R7
  cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr)
      && $stable(mem_cmd_read) && $stable(mem_cmd_wdata) && $stable(mem_cmd_size)));

  // R6
  reserved_local_chk: assert property (@(posedge clk) disable iff (rst)
    (cu_cmd_valid && cu_cmd_ready && cu_cmd_size == SZ_RSV)
      |=> (!mem_cmd_valid && cu_rsp_valid && cu_rsp_err));

  // R2
  core_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (core_cmd_valid && core_cmd_ready && core_cmd_size != SZ_RSV)
      |=> (mem_cmd_valid && mem_cmd_addr == $past(core_cmd_addr)));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid || core_rsp_valid || cu_rsp_valid) |-> !(core_cmd_ready || cu_cmd_ready));
endmodule

// File: tb/tb_cmp_mem_arbiter.sv
module tb_cmp_mem_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst;
  logic          core_cmd_valid, core_cmd_ready, core_cmd_read;
  logic [AW-1:0] core_cmd_addr;
  logic [DW-1:0] core_cmd_wdata;
  logic [1:0]    core_cmd_size;
  logic          core_rsp_valid, core_rsp_ready, core_rsp_err;
  logic [DW-1:0] core_rsp_rdata;
  logic          cu_holdup, cu_cmd_valid, cu_cmd_ready, cu_cmd_read;
  logic [AW-1:0] cu_cmd_addr;
  logic [DW-1:0] cu_cmd_wdata;
  logic [1:0]    cu_cmd_size;
  logic          cu_rsp_valid, cu_rsp_ready, cu_rsp_err;
  logic [DW-1:0] cu_rsp_rdata;
  logic          mem_cmd_valid, mem_cmd_ready, mem_cmd_read;
  logic [AW-1:0] mem_cmd_addr;
  logic [DW-1:0] mem_cmd_wdata;
  logic [1:0]    mem_cmd_size;
  logic          mem_rsp_valid, mem_rsp_ready, mem_rsp_err;
  logic [DW-1:0] mem_rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    core_cmd_valid = 0; core_cmd_addr = '0; core_cmd_read = 0; core_cmd_wdata = '0;
    core_cmd_size = 2'b10; core_rsp_ready = 0;
    cu_holdup = 0; cu_cmd_valid = 0; cu_cmd_addr = '0; cu_cmd_read = 0;
    cu_cmd_wdata = '0; cu_cmd_size = 2'b10; cu_rsp_ready = 0;
    mem_cmd_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = '0; mem_rsp_err = 0;
  endtask

  // Waits for the downstream command, checks it, stalls, then answers.
  task automatic mem_serve(input string req, input logic [AW-1:0] a, input logic rd,
                           input logic [DW-1:0] wd, input logic [1:0] sz,
                           input int stall, input logic [DW-1:0] rdata, input logic err);
    chk(mem_cmd_valid == 1'b1, req, mem_cmd_valid, 1);
    chk(mem_cmd_addr == a, req, mem_cmd_addr, a);
    chk(mem_cmd_read == rd, req, mem_cmd_read, rd);
    chk(mem_cmd_size == sz, req, mem_cmd_size, sz);
    if (!rd) chk(mem_cmd_wdata == wd, req, mem_cmd_wdata, wd);
    for (int i = 0; i < stall; i++) begin
      tick();
      chk(mem_cmd_valid && mem_cmd_addr == a && mem_cmd_size == sz, "R7", mem_cmd_addr, a);
    end
    mem_cmd_ready = 1;
    tick();
    mem_cmd_ready = 0;
    chk(mem_rsp_ready == 1'b1, req, mem_rsp_ready, 1);
    mem_rsp_valid = 1; mem_rsp_rdata = rdata; mem_rsp_err = err;
    tick();
    mem_rsp_valid = 0; mem_rsp_rdata = '0; mem_rsp_err = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    tick(); tick();
    rst = 0;
    tick();
    // R1
    chk(!mem_cmd_valid && !mem_rsp_ready, "R1", {mem_cmd_valid, mem_rsp_ready}, 0);
    chk(!core_rsp_valid && !cu_rsp_valid, "R1", {core_rsp_valid, cu_rsp_valid}, 0);
    chk(!core_cmd_ready && !cu_cmd_ready, "R1", {core_cmd_ready, cu_cmd_ready}, 0);
  endtask

  task automatic t_core_read();
    core_cmd_valid = 1; core_cmd_addr = 32'h8000_0040; core_cmd_read = 1; core_cmd_size = 2'b10;
    #1;
    chk(core_cmd_ready == 1'b1, "R2", core_cmd_ready, 1);
    tick();
    core_cmd_valid = 0;
    mem_serve("R2", 32'h8000_0040, 1'b1, '0, 2'b10, 2, 32'hCAFE_0001, 1'b0);
    chk(core_rsp_valid && !cu_rsp_valid, "R5", {core_rsp_valid, cu_rsp_valid}, 2'b10);
    chk(core_rsp_rdata == 32'hCAFE_0001 && !core_rsp_err, "R5", core_rsp_rdata, 32'hCAFE_0001);
    tick(); tick();
    chk(core_rsp_valid && core_rsp_rdata == 32'hCAFE_0001, "R8", core_rsp_valid, 1);
    chk(!core_cmd_ready && !cu_cmd_ready && !mem_cmd_valid, "R8", mem_cmd_valid, 0);
    core_rsp_ready = 1;
    tick();
    core_rsp_ready = 0;
    chk(!core_rsp_valid, "R8", core_rsp_valid, 0);
  endtask

  task automatic t_core_write_byte();
    core_cmd_valid = 1; core_cmd_addr = 32'h9000_0003; core_cmd_read = 0;
    core_cmd_wdata = 32'h0000_005A; core_cmd_size = 2'b00;
    #1;
    chk(core_cmd_ready == 1'b1, "R10", core_cmd_ready, 1);
    tick();
    core_cmd_valid = 0;
    mem_serve("R10", 32'h9000_0003, 1'b0, 32'h0000_005A, 2'b00, 0, 32'h0, 1'b1);
    chk(core_rsp_valid && core_rsp_err, "R5", core_rsp_err, 1);
    core_rsp_ready = 1;
    tick();
    core_rsp_ready = 0;
  endtask

  task automatic t_holdup_block();
    cu_holdup = 1;
    core_cmd_valid = 1; core_cmd_addr = 32'h1111_0000; core_cmd_read = 1; core_cmd_size = 2'b10;
    #1;
    for (int i = 0; i < 3; i++) begin
      chk(!core_cmd_ready, "R3", core_cmd_ready, 0);
      tick();
      chk(!mem_cmd_valid, "R3", mem_cmd_valid, 0);
    end
    cu_cmd_valid = 1; cu_cmd_addr = 32'h2222_0010; cu_cmd_read = 0;
    cu_cmd_wdata = 32'hBEEF_1234; cu_cmd_size = 2'b01;
    #1;
    chk(cu_cmd_ready && !core_cmd_ready, "R3", {cu_cmd_ready, core_cmd_ready}, 2'b10);
    tick();
    cu_cmd_valid = 0;
    mem_serve("R3", 32'h2222_0010, 1'b0, 32'hBEEF_1234, 2'b01, 1, 32'h7777_0002, 1'b0);
    chk(cu_rsp_valid && !core_rsp_valid, "R5", {cu_rsp_valid, core_rsp_valid}, 2'b10);
    chk(cu_rsp_rdata == 32'h7777_0002, "R5", cu_rsp_rdata, 32'h7777_0002);
    cu_rsp_ready = 1;
    tick();
    cu_rsp_ready = 0;
    cu_holdup = 0;
    #1;
    chk(core_cmd_ready == 1'b1, "R2", core_cmd_ready, 1);
    tick();
    core_cmd_valid = 0;
    mem_serve("R2", 32'h1111_0000, 1'b1, '0, 2'b10, 0, 32'h0BAD_F00D, 1'b0);
    chk(core_rsp_valid && core_rsp_rdata == 32'h0BAD_F00D, "R5", core_rsp_rdata, 32'h0BAD_F00D);
    core_rsp_ready = 1;
    tick();
    core_rsp_ready = 0;
  endtask

  task automatic t_priority();
    core_cmd_valid = 1; core_cmd_addr = 32'h3000_0000; core_cmd_read = 1; core_cmd_size = 2'b10;
    cu_cmd_valid = 1; cu_cmd_addr = 32'h4000_0000; cu_cmd_read = 1; cu_cmd_size = 2'b10;
    #1;
    chk(core_cmd_ready && !cu_cmd_ready, "R9", {core_cmd_ready, cu_cmd_ready}, 2'b10);
    tick();
    core_cmd_valid = 0;
    #1;
    chk(!cu_cmd_ready, "R8", cu_cmd_ready, 0);
    mem_serve("R9", 32'h3000_0000, 1'b1, '0, 2'b10, 0, 32'h0000_0033, 1'b0);
    chk(core_rsp_valid && !cu_rsp_valid, "R9", {core_rsp_valid, cu_rsp_valid}, 2'b10);
    core_rsp_ready = 1;
    tick();
    core_rsp_ready = 0;
    // Co-unit request left over is served once the block is free again.
    #1;
    chk(cu_cmd_ready == 1'b1, "R9", cu_cmd_ready, 1);
    tick();
    cu_cmd_valid = 0;
    mem_serve("R9", 32'h4000_0000, 1'b1, '0, 2'b10, 0, 32'h0000_0044, 1'b0);
    chk(cu_rsp_valid && cu_rsp_rdata == 32'h0000_0044, "R5", cu_rsp_rdata, 32'h44);
    cu_rsp_ready = 1;
    tick();
    cu_rsp_ready = 0;
  endtask

  task automatic t_inflight();
    core_cmd_valid = 1; core_cmd_addr = 32'h5000_0008; core_cmd_read = 1; core_cmd_size = 2'b10;
    #1;
    chk(core_cmd_ready == 1'b1, "R4", core_cmd_ready, 1);
    tick();
    core_cmd_valid = 0;
    cu_holdup = 1;
    cu_cmd_valid = 1; cu_cmd_addr = 32'h6000_0000; cu_cmd_read = 1; cu_cmd_size = 2'b10;
    #1;
    chk(!cu_cmd_ready, "R8", cu_cmd_ready, 0);
    mem_serve("R4", 32'h5000_0008, 1'b1, '0, 2'b10, 1, 32'h1234_5678, 1'b0);
    chk(core_rsp_valid && core_rsp_rdata == 32'h1234_5678, "R4", core_rsp_rdata, 32'h1234_5678);
    chk(!cu_rsp_valid && !cu_cmd_ready, "R8", cu_cmd_ready, 0);
    core_rsp_ready = 1;
    tick();
    core_rsp_ready = 0;
    #1;
    chk(cu_cmd_ready == 1'b1, "R3", cu_cmd_ready, 1);
    tick();
    cu_cmd_valid = 0;
    mem_serve("R3", 32'h6000_0000, 1'b1, '0, 2'b10, 0, 32'h0000_0066, 1'b0);
    cu_rsp_ready = 1;
    tick();
    cu_rsp_ready = 0;
    cu_holdup = 0;
  endtask

  task automatic t_reserved();
    cu_holdup = 1;
    cu_cmd_valid = 1; cu_cmd_addr = 32'h7000_0000; cu_cmd_read = 1; cu_cmd_size = 2'b11;
    #1;
    chk(cu_cmd_ready == 1'b1, "R6", cu_cmd_ready, 1);
    tick();
    cu_cmd_valid = 0;
    chk(!mem_cmd_valid, "R6", mem_cmd_valid, 0);
    chk(cu_rsp_valid && cu_rsp_err && cu_rsp_rdata == '0, "R6", {cu_rsp_valid, cu_rsp_err}, 2'b11);
    chk(!core_rsp_valid, "R6", core_rsp_valid, 0);
    cu_rsp_ready = 1;
    tick();
    cu_rsp_ready = 0;
    chk(!mem_cmd_valid && !cu_rsp_valid, "R6", mem_cmd_valid, 0);
    cu_holdup = 0;
  endtask

  initial begin
    t_reset();
    t_core_read();
    t_core_write_byte();
    t_holdup_block();
    t_priority();
    t_inflight();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule